// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Oscillator

This block is a numerically controlled oscillator built around one CORDIC rotation stage that is reused on every clock. A phase accumulator advances once per sample period by a tuning word, and the rotator then spends N clocks refining that phase into a signed cosine and sine pair. N is the output word width. The output rate is therefore one sample every N enabled clocks.

An offset on the step (frequency modulation) and an offset on the phase (phase modulation) can be applied. Each of them can be given a register stage that holds for a whole sample period. An optional dither source adds pseudo-random noise below the phase truncation point. The phase is first folded into the first quadrant using its two top bits, and the quadrant is restored at the output by swapping and negating. The rotator starts from the reciprocal of the CORDIC gain, so the outputs need no scaling multiply.

Top module: `cordic_nco`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `sin_out` and `cos_out` are all zero.
- R2: After reset is released, `out_valid` first rises after the 2N+2-th rising clock edge at which `en` is high. Edges with `en` low are not counted.
- R3: `out_valid` is a one-clock pulse. Successive pulses are exactly N enabled clock edges apart.
- R4: With constant inputs, the j-th valid sample (j = 1, 2, ...) has phase j*(`phase_inc`+`freq_mod`)+`phase_mod` modulo 2^PW, where 2^PW is a full turn. The outputs are `cos_out` = round(A*cos) and `sin_out` = round(A*sin), with A = 2^(N-1)-1, within 4 LSB at the default N of 16.
- R5: All four quadrants carry the correct signs. Phases of 0, 1/4, 1/2 and 3/4 turn give (cos, sin) near (A,0), (0,A), (-A,0) and (0,-A).
- R6: `freq_mod` is added to the step on every sample, so the phase advances by `phase_inc`+`freq_mod` per sample.
- R7: `phase_mod` shifts each sample's phase by its value and does not accumulate. With a zero step, every sample shows the same offset angle.
- R8: While `en` is low nothing advances. `out_valid` stays low, `sin_out` and `cos_out` hold their values, and the sample schedule and phase sequence continue unchanged once `en` returns.
- R9: The latency grows by 2 clocks when DITHER=1, by N clocks when FM_REG=1 and by N clocks when PM_REG=1. At N=8 with all three enabled, the first pulse follows the 36th enabled edge.
- R10: Neither output ever leaves the range -A..+A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; all state advances only when high |
| phase_inc | input | PW | Phase step per sample, 2^PW = one turn |
| freq_mod | input | PW | Offset added to the phase step |
| phase_mod | input | PW | Offset added to the accumulated phase |
| sin_out | output | N | Signed sine sample |
| cos_out | output | N | Signed cosine sample |
| out_valid | output | 1 | One-clock pulse marking a new sample |

## Verification
The hardest behaviour to reach from the ports is a clock-enable stall that lands right after a sample has been issued. The stall must leave the rotation in progress, the output registers and the sample count intact. To get there, the stimulus waits for a pulse and then drops `en` for several clocks, checking at each one that the outputs hold. It then counts the enabled edges to the next pulse and compares that sample's value against the phase two steps in. A second instance with dither and both modulation registers enabled runs from the same stimulus, so the added latencies are measured against the same reference phases.

// File: rtl/cordic_nco.sv
module cordic_nco #(
  parameter int N      = 16,
  parameter int PW     = 32,
  parameter int AW     = 24,
  parameter int G      = 3,
  parameter int DITHER = 0,
  parameter int FM_REG = 0,
  parameter int PM_REG = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [PW-1:0]        phase_inc,
  input  logic [PW-1:0]        freq_mod,
  input  logic [PW-1:0]        phase_mod,
  output logic signed [N-1:0]  sin_out,
  output logic signed [N-1:0]  cos_out,
  output logic                 out_valid
);
  localparam int CW  = $clog2(N);
  localparam int XW  = N + G + 1;
  localparam int ZW  = AW + 1;
  localparam int DLY = 2 + 2*DITHER;
  localparam logic [63:0] AMP = (64'd1 << (N-1)) - 64'd1;
  localparam logic [63:0] X0W = (AMP * 64'd652032875) >> (30 - G);
  localparam logic signed [XW-1:0] X0   = XW'(X0W);
  localparam logic signed [XW-1:0] AMPX = XW'(AMP);
  localparam logic signed [XW-1:0] HALF = XW'(64'd1 << (G-1));
  localparam logic [PW-1:0] DMASK = (PW'(1) << (PW-AW)) - PW'(1);

  function automatic logic [31:0] atan_turn(input logic [4:0] i);
    case (i)
      5'd0:  return 32'h2000_0000;
      5'd1:  return 32'h12E4_051E;
      5'd2:  return 32'h09FB_385B;
      5'd3:  return 32'h0511_11D4;
      5'd4:  return 32'h028B_0D43;
      5'd5:  return 32'h0145_D7E1;
      5'd6:  return 32'h00A2_F61E;
      5'd7:  return 32'h0051_7C55;
      5'd8:  return 32'h0028_BE53;
      5'd9:  return 32'h0014_5F2F;
      5'd10: return 32'h000A_2F98;
      5'd11: return 32'h0005_17CC;
      5'd12: return 32'h0002_8BE6;
      5'd13: return 32'h0001_45F3;
      5'd14: return 32'h0000_A2FA;
      5'd15: return 32'h0000_517D;
      5'd16: return 32'd10430;
      5'd17: return 32'd5215;
      5'd18: return 32'd2608;
      5'd19: return 32'd1304;
      5'd20: return 32'd652;
      5'd21: return 32'd326;
      5'd22: return 32'd163;
      5'd23: return 32'd81;
      5'd24: return 32'd41;
      5'd25: return 32'd20;
      5'd26: return 32'd10;
      5'd27: return 32'd5;
      5'd28: return 32'd3;
      5'd29: return 32'd1;
      5'd30: return 32'd1;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic signed [N-1:0] fit(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] t;
    t = (v + HALF) >>> G;
    if (t > AMPX) t = AMPX;
    else if (t < -AMPX) t = -AMPX;
    return t[N-1:0];
  endfunction

  logic [CW-1:0] cnt;
  wire frame = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (en) cnt <= (cnt == CW'(N-1)) ? '0 : cnt + 1'b1;

  logic [PW-1:0] step, acc, ph_src, dith;
  logic step_ok, acc_v, ph_ok;

  generate
    if (FM_REG != 0) begin : g_fm_reg
      logic [PW-1:0] step_q;
      logic step_qv;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          step_q <= '0; step_qv <= 1'b0;
        end else if (en && frame) begin
          step_q <= phase_inc + freq_mod; step_qv <= 1'b1;
        end
      assign step = step_q;
      assign step_ok = step_qv;
    end else begin : g_fm_dir
      assign step = phase_inc + freq_mod;
      assign step_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0; acc_v <= 1'b0;
    end else if (en && frame) begin
      acc <= acc + step; acc_v <= step_ok;
    end

  generate
    if (PM_REG != 0) begin : g_pm_reg
      logic [PW-1:0] ph_q;
      logic ph_qv;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ph_q <= '0; ph_qv <= 1'b0;
        end else if (en && frame) begin
          ph_q <= acc + phase_mod; ph_qv <= acc_v;
        end
      assign ph_src = ph_q;
      assign ph_ok = ph_qv;
    end else begin : g_pm_dir
      assign ph_src = acc + phase_mod;
      assign ph_ok = acc_v;
    end

    if (DITHER != 0) begin : g_dith
      logic [15:0] lfsr;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) lfsr <= 16'hACE1;
        else if (en && frame)
          lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      assign dith = PW'(lfsr) & DMASK;
    end else begin : g_nodith
      assign dith = '0;
    end
  endgenerate

  wire [PW-1:0] ph_d = ph_src + dith;
  wire [AW-1:0] ang = ph_d[PW-1 -: AW];
  wire signed [ZW-1:0] z_ld = $signed({3'b000, ang[AW-3:0]});

  wire [31:0] at32 = atan_turn(5'(cnt));
  wire [31:0] at_sh = at32 >> (31 - AW);
  wire [31:0] at_r = (at_sh + 32'd1) >> 1;
  wire signed [ZW-1:0] atn = $signed(at_r[ZW-1:0]);

  logic signed [XW-1:0] x, y;
  logic signed [ZW-1:0] z;
  logic [1:0] quad;
  logic rot_v;

  wire signed [XW-1:0] xi = frame ? X0 : x;
  wire signed [XW-1:0] yi = frame ? '0 : y;
  wire signed [ZW-1:0] zi = frame ? z_ld : z;
  wire signed [XW-1:0] xs = xi >>> cnt;
  wire signed [XW-1:0] ys = yi >>> cnt;
  wire ccw = ~zi[ZW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      x <= '0; y <= '0; z <= '0; quad <= '0; rot_v <= 1'b0;
    end else if (en) begin
      x <= ccw ? xi - ys : xi + ys;
      y <= ccw ? yi + xs : yi - xs;
      z <= ccw ? zi - atn : zi + atn;
      if (frame) begin
        quad  <= ang[AW-1:AW-2];
        rot_v <= ph_ok;
      end
    end

  wire signed [N-1:0] xr = fit(x);
  wire signed [N-1:0] yr = fit(y);
  logic signed [N-1:0] c_n, s_n;

  always_comb
    case (quad)
      2'd0:    begin c_n = xr;  s_n = yr;  end
      2'd1:    begin c_n = -yr; s_n = xr;  end
      2'd2:    begin c_n = -xr; s_n = -yr; end
      default: begin c_n = yr;  s_n = -xr; end
    endcase

  logic signed [N-1:0] c_d [DLY];
  logic signed [N-1:0] s_d [DLY];
  logic [DLY-1:0] v_d;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < DLY; k++) begin
        c_d[k] <= '0; s_d[k] <= '0;
      end
      v_d <= '0; en_q <= 1'b0;
    end else begin
      en_q <= en;
      if (en) begin
        if (frame) begin
          c_d[0] <= c_n; s_d[0] <= s_n;
        end
        v_d[0] <= frame & rot_v;
        for (int k = 1; k < DLY; k++) begin
          c_d[k] <= c_d[k-1]; s_d[k] <= s_d[k-1]; v_d[k] <= v_d[k-1];
        end
      end
    end

  assign cos_out   = c_d[DLY-1];
  assign sin_out   = s_d[DLY-1];
  assign out_valid = v_d[DLY-1] & en_q;
endmodule

// File: rtl/cordic_nco_chk.sv
module cordic_nco_chk #(
  parameter int N      = 16,
  parameter int DITHER = 0,
  parameter int FM_REG = 0,
  parameter int PM_REG = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic signed [N-1:0] sin_out,
  input logic signed [N-1:0] cos_out,
  input logic                out_valid
);
  localparam int LAT = 2*N + 2 + 2*DITHER + N*(FM_REG + PM_REG);
  localparam logic signed [N:0] LIM = (N+1)'((64'd1 << (N-1)) - 64'd1);

  logic [7:0] gap;
  logic [15:0] since;
  logic seen;
  wire signed [N:0] s_x = sin_out;
  wire signed [N:0] c_x = cos_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gap <= '0; since <= '0; seen <= 1'b0;
    end else begin
      if (out_valid) begin
        seen <= 1'b1;
        gap  <= en ? 8'd1 : 8'd0;
      end else begin
        gap <= gap + (en ? 8'd1 : 8'd0);
      end
      if (!seen) since <= since + (en ? 16'd1 : 16'd0);
    end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3
  pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen) |-> (gap == 8'(N)));

  // R2 R9
  first_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !seen) |-> (since == 16'(LAT)));

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(sin_out) && $stable(cos_out)));

  // R10
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (s_x <= LIM && s_x >= -LIM && c_x <= LIM && c_x >= -LIM));
endmodule

bind cordic_nco cordic_nco_chk #(.N(N), .DITHER(DITHER), .FM_REG(FM_REG), .PM_REG(PM_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
);

// File: tb/test_cordic_nco.sv
module test_cordic_nco;
  localparam int CLK_NS = 10;
  localparam int NA = 16;
  localparam int NB = 8;
  localparam int AMPA = 32767;
  localparam int AMPB = 127;
  localparam int NV = 7;
  localparam logic [95:0] VEC [NV] = '{
    {32'h4000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h0123_4567, 32'h0000_0000, 32'h0000_0000},
    {32'h1000_0000, 32'h0200_0000, 32'h0000_0000},
    {32'h2000_0000, 32'h0000_0000, 32'h1555_5555},
    {32'hE000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_0000, 32'hC000_0000},
    {32'h3333_3333, 32'h0000_1000, 32'h8000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] inc = '0, fm = '0, pm = '0;
  wire signed [NA-1:0] s_a, c_a;
  wire signed [NB-1:0] s_b, c_b;
  wire va, vb;
  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  cordic_nco #(.N(NA)) i_cordic_nco (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(inc), .freq_mod(fm), .phase_mod(pm),
    .sin_out(s_a), .cos_out(c_a), .out_valid(va));

  cordic_nco #(.N(NB), .DITHER(1), .FM_REG(1), .PM_REG(1)) i_cordic_nco_x (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(inc), .freq_mod(fm), .phase_mod(pm),
    .sin_out(s_b), .cos_out(c_b), .out_valid(vb));

  function automatic string tag_of(input int vi);
    case (vi)
      0: return "R5";
      2: return "R6";
      3, 5: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic chk_eq(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_val(input string tag, input logic [31:0] ph, input int gs, input int gc,
                         input int amp, input int tol);
    real a, es, ec, ds, dc;
    a  = real'(ph) * 6.283185307179586 / 4294967296.0;
    es = real'(amp) * $sin(a);
    ec = real'(amp) * $cos(a);
    ds = real'(gs) - es; if (ds < 0.0) ds = -ds;
    dc = real'(gc) - ec; if (dc < 0.0) dc = -dc;
    checks++;
    if (ds > real'(tol) || dc > real'(tol)) begin
      errors++;
      $display("FAIL %s phase %h got sin %0d cos %0d expected sin %0.1f cos %0.1f",
               tag, ph, gs, gc, es, ec);
    end
  endtask

  task automatic do_reset(input bit look);
    rst_n = 1'b0;
    en = 1'b0;
    repeat (2) @(negedge clk);
    if (look) begin
      // R1
      chk_eq("R1 valid", int'(va) + int'(vb), 0);
      chk_eq("R1 sin", int'(s_a) + int'(s_b), 0);
      chk_eq("R1 cos", int'(c_a) + int'(c_b), 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk);
      if (en) n++;
      @(negedge clk);
      if (va) return;
    end
    n = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, sa, ca;
    for (int vi = 0; vi < NV; vi++) begin
      int ne, na, nb, lasta;
      inc = VEC[vi][95:64];
      fm  = VEC[vi][63:32];
      pm  = VEC[vi][31:0];
      do_reset(vi == 0);
      en = 1'b1;
      ne = 0; na = 0; nb = 0; lasta = 0;
      for (int c = 0; c < 150 && (na < 4 || nb < 2); c++) begin
        @(posedge clk);
        ne++;
        @(negedge clk);
        if (va) begin
          if (na == 0) chk_eq("R2 first latency", ne, 2*NA + 2);
          else chk_eq("R3 spacing", ne - lasta, NA);
          lasta = ne;
          na++;
          chk_val(tag_of(vi), (inc + fm) * 32'(na) + pm, int'(s_a), int'(c_a), AMPA, 4);
        end
        if (vb && nb < 2) begin
          nb++;
          if (nb == 1) chk_eq("R9 latency", ne, 4*NB + 4);
          chk_val("R9", (inc + fm) * 32'(nb) + pm, int'(s_b), int'(c_b), AMPB, 3);
        end
      end
      chk_eq("R3 sample count", na, 4);
      chk_eq("R9 sample count", nb, 2);
    end

    // R8: enable held low after reset, latency counts enabled edges only
    inc = 32'h0800_0000; fm = '0; pm = '0;
    do_reset(1'b0);
    en = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (va) chk_eq("R8 idle valid", 1, 0);
    end
    chk_eq("R8 idle quiet", int'(va), 0);
    en = 1'b1;
    wait_valid(n);
    chk_eq("R8 latency after idle", n, 2*NA + 2);
    chk_val("R8", inc, int'(s_a), int'(c_a), AMPA, 4);

    // R8: stall right after a pulse
    sa = int'(s_a); ca = int'(c_a);
    en = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk_eq("R8 stall valid", int'(va), 0);
      chk_eq("R8 stall sin hold", int'(s_a), sa);
      chk_eq("R8 stall cos hold", int'(c_a), ca);
    end
    en = 1'b1;
    wait_valid(n);
    chk_eq("R8 spacing across stall", n, NA);
    chk_val("R8", inc * 32'd2, int'(s_a), int'(c_a), AMPA, 4);
    @(negedge clk);
    chk_eq("R3 pulse ends", int'(va), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule